// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and the memories of a plug-in cartridge: a 1 MB ROM and a 16 kB battery-backed SRAM. The CPU window 0x4000-0xBFFF is split into four 8 kB windows. Each window shows one of 128 ROM pages, chosen by a page register. The CPU writes these registers by storing to the window's 0x0FFF offset. A finer overlay can replace the upper half of the second window (0x7000-0x7FFF). It uses two 2 kB sub-page registers that index the upper 512 kB of the ROM.

Bit 7 of the value stored into the first page register switches the SRAM into 0x0000-0x3FFF. Bit 7 of the value stored into the second page register switches the overlay on. Address decode, chip selects and read data steering are combinational within a bus cycle. Register stores take effect on the following bus cycle. Reads that hit nothing return 0xFF.

Top module: `cart_mapper`

## Requirements
- R1: After reset, all four page registers and both sub-page registers are zero, and the SRAM and the overlay are both disabled. A read of 0x0000-0x3FFF returns 0xFF with no chip select, and a read of 0x4000 drives ROM address 0.
- R2: A write anywhere in 0x4000-0xBFFF with address bits [12:0] equal to 0x0FFF loads page register (address[15:13] - 2) with data bits [6:0], so the page wraps within 128. The new value is used from the next bus cycle.
- R3: A read in 0x4000-0xBFFF outside an active overlay asserts rom_cs and drives rom_addr = {page register of that window, address[12:0]}. bus_rdata then equals rom_rdata.
- R4: A write to 0x77FF loads sub-page register 0 and a write to 0x7FFF loads sub-page register 1, each with all 8 data bits. Neither write changes any page register.
- R5: While the overlay is enabled, a read in 0x7000-0x7FFF drives rom_addr = 0x80000 + sub*0x800 + (address & 0x7FF). Sub-page register 0 serves addresses below 0x7800 and register 1 serves 0x7800 and above.
- R6: Data bit 7 of a page-register-1 write sets (1) or clears (0) the overlay enable. While the overlay is disabled, 0x7000-0x7FFF reads come from window 1, and sub-page registers still accept writes.
- R7: Data bit 7 of a page-register-0 write sets or clears the SRAM enable. While the SRAM is enabled, an access in 0x0000-0x3FFF asserts sram_cs with sram_addr = address[13:0], and a read there returns sram_rdata.
- R8: sram_we is asserted only for a bus write in 0x0000-0x3FFF while the SRAM is enabled. Writes there while it is disabled leave the SRAM contents unchanged.
- R9: Reads of 0xC000-0xFFFF, and reads of 0x0000-0x3FFF while the SRAM is disabled, return 0xFF and assert neither chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rdata | output | 8 | Read data returned to the CPU (0xFF when unmapped) |
| rom_addr | output | 20 | ROM byte address |
| rom_cs | output | 1 | ROM chip select (reads only) |
| rom_rdata | input | 8 | ROM data |
| sram_addr | output | 14 | SRAM byte address |
| sram_cs | output | 1 | SRAM chip select |
| sram_we | output | 1 | SRAM write enable |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM data |

## Verification
The bench targets the overlap between the overlay and window 1. A design that ignores the enable, or keys the sub-page choice off the wrong address bit, returns the wrong ROM byte somewhere in 0x7000-0x7FFF. Sub-page stores made while the overlay is off must still land, and must not disturb page register 1. A decoder that only matches 0x6FFF, or matches 0x77FF too loosely, is exposed there. SRAM stores made while the SRAM is disabled are later read back after re-enabling it, so a missing write gate shows up as corrupted data. Writing 0xC3 to a page register checks that bit 7 is dropped from the page number, which would otherwise point outside the ROM or alias the flags.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    localparam int CPU_AW      = 16;
    localparam int CPU_DW      = 8;
    localparam int NUM_MAIN    = 4;
    localparam int NUM_SUB     = 2;
    localparam int MAIN_PG_W   = 7;
    localparam int SUB_PG_W    = 8;
    localparam int MAIN_OFS_W  = 13;
    localparam int SUB_OFS_W   = 11;
    localparam int SRAM_AW     = 14;
    localparam int ROM_AW      = MAIN_PG_W + MAIN_OFS_W;
    localparam int MAIN_IDX_W  = $clog2(NUM_MAIN);
    localparam int SUB_IDX_W   = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;

    localparam logic [MAIN_OFS_W-1:0] REG_OFS  = 13'h0FFF;
    localparam logic [CPU_AW-1:0]     SUB0_REG = 16'h77FF;
    localparam logic [CPU_AW-1:0]     SUB1_REG = 16'h7FFF;
    localparam logic [3:0]            OVL_NIB  = 4'h7;
    localparam logic [CPU_DW-1:0]     IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_SRAM,
        RG_MAIN,
        RG_SUB
    } region_e;

    typedef struct packed {
        logic [NUM_MAIN-1:0][MAIN_PG_W-1:0] page;
        logic [NUM_SUB-1:0][SUB_PG_W-1:0]   sub;
        logic                               sram_on;
        logic                               ovl_on;
    } map_state_t;

    // window 0 starts at 0x4000, so the slot is address[15:13] minus two
    function automatic logic [MAIN_IDX_W-1:0] window_of(input logic [CPU_AW-1:0] a);
        logic [2:0] t;
        t = a[15:13] - 3'd2;
        return t[MAIN_IDX_W-1:0];
    endfunction

    function automatic logic in_rom_span(input logic [CPU_AW-1:0] a);
        return (a[15:14] == 2'b01) || (a[15:14] == 2'b10);
    endfunction

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CPU_AW-1:0] addr,
    input  logic [CPU_DW-1:0] wdata,
    output map_state_t        st
);

    logic is_sub0, is_sub1, is_main;
    logic [MAIN_IDX_W-1:0] slot;

    always_comb begin
        is_sub0 = wr && (addr == SUB0_REG);
        is_sub1 = wr && (addr == SUB1_REG);
        is_main = wr && in_rom_span(addr) && (addr[MAIN_OFS_W-1:0] == REG_OFS)
                  && !is_sub0 && !is_sub1;
        slot    = window_of(addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (is_sub0) st.sub[0] <= wdata;
            if (is_sub1) st.sub[NUM_SUB-1] <= wdata;
            if (is_main) begin
                st.page[slot] <= wdata[MAIN_PG_W-1:0];
                if (slot == 0) st.sram_on <= wdata[CPU_DW-1];
                if (slot == 1) st.ovl_on  <= wdata[CPU_DW-1];
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st == '0));

    p_bank0_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'h4FFF) |=> (st.page[0] == $past(wdata[MAIN_PG_W-1:0])));

    p_sub_keeps_pages_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == 16'h77FF || addr == 16'h7FFF)) |=> $stable(st.page));

    p_ovl_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'h6FFF) |=> (st.ovl_on == $past(wdata[CPU_DW-1])));

    p_sram_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'h4FFF) |=> (st.sram_on == $past(wdata[CPU_DW-1])));

endmodule

// File: rtl/cart_region_decode.sv
module cart_region_decode
    import cart_mapper_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  map_state_t        st,
    output region_e           region,
    output logic [ROM_AW-1:0] rom_addr
);

    logic                  sub_sel;
    logic [SUB_PG_W-1:0]   sub_pg;
    logic [MAIN_PG_W-1:0]  main_pg;

    always_comb begin
        sub_sel = addr[SUB_OFS_W];
        sub_pg  = sub_sel ? st.sub[NUM_SUB-1] : st.sub[0];
        main_pg = st.page[window_of(addr)];
        if (addr[15:14] == 2'b00) begin
            region   = st.sram_on ? RG_SRAM : RG_NONE;
            rom_addr = '0;
        end else if (addr[15:14] == 2'b11) begin
            region   = RG_NONE;
            rom_addr = '0;
        end else if (st.ovl_on && addr[15:12] == OVL_NIB) begin
            region   = RG_SUB;
            rom_addr = {1'b1, sub_pg, addr[SUB_OFS_W-1:0]};
        end else begin
            region   = RG_MAIN;
            rom_addr = {main_pg, addr[MAIN_OFS_W-1:0]};
        end
    end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_rd,
    input  logic               bus_wr,
    output logic [7:0]         bus_rdata,
    output logic [19:0]        rom_addr,
    output logic               rom_cs,
    input  logic [7:0]         rom_rdata,
    output logic [13:0]        sram_addr,
    output logic               sram_cs,
    output logic               sram_we,
    output logic [7:0]         sram_wdata,
    input  logic [7:0]         sram_rdata
);

    map_state_t st;
    region_e    region;

    cart_bank_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .st    (st)
    );

    cart_region_decode u_dec (
        .addr     (bus_addr),
        .st       (st),
        .region   (region),
        .rom_addr (rom_addr)
    );

    always_comb begin
        rom_cs     = bus_rd && (region == RG_MAIN || region == RG_SUB);
        sram_cs    = (bus_rd || bus_wr) && (region == RG_SRAM);
        sram_we    = bus_wr && (region == RG_SRAM);
        sram_addr  = bus_addr[SRAM_AW-1:0];
        sram_wdata = bus_wdata;
        if (rom_cs)
            bus_rdata = rom_rdata;
        else if (bus_rd && region == RG_SRAM)
            bus_rdata = sram_rdata;
        else
            bus_rdata = IDLE_BYTE;
    end

    p_overlay_upper_half_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && st.ovl_on && bus_addr[15:12] == 4'h7) |-> (rom_cs && rom_addr[19]));

    p_sram_we_gate_r8: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (st.sram_on && bus_wr && bus_addr[15:14] == 2'b00));

    p_unmapped_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[15:14] == 2'b11) |-> (!rom_cs && !sram_cs && bus_rdata == 8'hFF));

    p_rom_span_r3: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> (bus_addr[15:14] == 2'b01 || bus_addr[15:14] == 2'b10));

endmodule

// File: tb/cart_mapper_tb.sv
`timescale 1ns/100ps
module cart_mapper_tb;

    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_rdata;
    logic [19:0] rom_addr;
    logic        rom_cs;
    logic [7:0]  rom_rdata = '0;
    logic [13:0] sram_addr;
    logic        sram_cs, sram_we;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata = '0;

    int n_checks = 0, n_errors = 0;
    bit done = 0;

    // bench-side SRAM array, sparse
    logic [7:0] sram_mem [int];
    // reference model state
    int  m_page [4];
    int  m_sub  [2];
    bit  m_sram_on, m_ovl_on;
    int  m_sram [int];

    always #2.5 clk = ~clk;

    cart_mapper u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata),
        .sram_addr(sram_addr), .sram_cs(sram_cs), .sram_we(sram_we),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    always @(posedge clk) if (sram_we) sram_mem[int'(sram_addr)] = sram_wdata;

    function automatic logic [7:0] rom_fn(input int a);
        logic [19:0] x;
        x = a[19:0];
        return x[7:0] ^ x[15:8] ^ {x[19:16], x[11:8]} ^ 8'h3C;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 4; i++) m_page[i] = 0;
        m_sub[0] = 0; m_sub[1] = 0;
        m_sram_on = 0; m_ovl_on = 0;
    endtask

    task automatic do_write(input int a, input int d, input string tag);
        bit exp_we;
        exp_we = (a < 'h4000) && m_sram_on;
        @(negedge clk);
        bus_addr = a[15:0]; bus_wdata = d[7:0]; bus_wr = 1; bus_rd = 0;
        #1;
        chk(tag, "sram_we", int'(sram_we), int'(exp_we));
        chk(tag, "rom_cs on write", int'(rom_cs), 0);
        @(posedge clk);
        #0.5;
        bus_wr = 0;
        if (a < 'h4000) begin
            if (m_sram_on) m_sram[a] = d;
        end else if (a < 'hC000) begin
            if (a == 'h77FF) m_sub[0] = d;
            else if (a == 'h7FFF) m_sub[1] = d;
            else if ((a % 8192) == 'h0FFF) begin
                int idx;
                idx = a / 8192 - 2;
                m_page[idx] = d % 128;
                if (idx == 0) m_sram_on = (d >= 128);
                if (idx == 1) m_ovl_on  = (d >= 128);
            end
        end
    endtask

    task automatic do_read(input int a, input string tag);
        bit exp_rom, exp_sram;
        int exp_ra, exp_d;
        exp_rom = 0; exp_sram = 0; exp_ra = 0; exp_d = 'hFF;
        if (a < 'h4000) begin
            if (m_sram_on) begin
                exp_sram = 1;
                exp_d = m_sram.exists(a) ? m_sram[a] : 0;
            end
        end else if (a < 'hC000) begin
            exp_rom = 1;
            if (m_ovl_on && a >= 'h7000 && a < 'h8000)
                exp_ra = 'h80000 + m_sub[(a >= 'h7800) ? 1 : 0] * 'h800 + (a % 'h800);
            else
                exp_ra = m_page[a / 8192 - 2] * 8192 + (a % 8192);
            exp_d = int'(rom_fn(exp_ra));
        end
        @(negedge clk);
        bus_addr = a[15:0]; bus_rd = 1; bus_wr = 0;
        #1;
        rom_rdata  = rom_fn(int'(rom_addr));
        sram_rdata = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 8'h00;
        #0.5;
        chk(tag, "rom_cs", int'(rom_cs), int'(exp_rom));
        chk(tag, "sram_cs", int'(sram_cs), int'(exp_sram));
        chk(tag, "sram_we on read", int'(sram_we), 0);
        if (exp_rom) chk(tag, "rom_addr", int'(rom_addr), exp_ra);
        if (exp_sram) chk(tag, "sram_addr", int'(sram_addr), a % 'h4000);
        chk(tag, "bus_rdata", int'(bus_rdata), exp_d);
        @(posedge clk);
        #0.5;
        bus_rd = 0;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #0.5 rst = 0;

        // R1: reset state
        do_read('h0000, "R1");
        do_read('h3FFF, "R1");
        do_read('h4000, "R1");
        do_read('h7000, "R1");
        do_read('h7800, "R1");
        do_read('hA123, "R1");
        // R9: top region unmapped
        do_read('hC000, "R9");
        do_read('hFFFF, "R9");

        // R2/R3: page loads, one takes effect the next cycle, 0xC3 wraps to 0x43
        do_write('h4FFF, 'h05, "R2");
        do_read('h4FFF, "R2");
        do_write('h6FFF, 'h12, "R2");
        do_write('h8FFF, 'h7F, "R2");
        do_write('hAFFF, 'hC3, "R2");
        do_read('h4000, "R3");
        do_read('h5ABC, "R3");
        do_read('h6000, "R3");
        do_read('h7FFF, "R3");
        do_read('h9FFF, "R3");
        do_read('hA000, "R3");
        do_read('hBFFF, "R3");
        do_read('h0010, "R9");
        // non-register ROM-area writes and top-area writes change nothing
        do_write('h5000, 'hEE, "R2");
        do_write('hC000, 'h99, "R2");
        do_write('hCFFF, 'h81, "R2");
        do_read('h4000, "R2");
        do_read('hA555, "R2");

        // R8: gated SRAM writes, R7: enable and access
        do_write('h0100, 'hAA, "R8");
        do_write('h4FFF, 'h85, "R7");
        do_read('h0100, "R8");
        do_write('h0100, 'h5A, "R7");
        do_write('h2345, 'h33, "R7");
        do_write('h3FFF, 'hC7, "R7");
        do_read('h0100, "R7");
        do_read('h2345, "R7");
        do_read('h3FFF, "R7");
        do_read('h4000, "R7");
        do_write('h4FFF, 'h05, "R7");
        do_read('h0100, "R9");
        do_write('h0100, 'h11, "R8");
        do_write('h2345, 'h22, "R8");
        do_write('h4FFF, 'h85, "R8");
        do_read('h0100, "R8");
        do_read('h2345, "R8");

        // R4/R6: sub-page loads while overlay is off
        do_write('h77FF, 'h03, "R4");
        do_write('h7FFF, 'hFE, "R4");
        do_read('h7000, "R6");
        do_read('h7800, "R6");
        do_read('h6000, "R4");
        // R5: overlay on
        do_write('h6FFF, 'h92, "R6");
        do_read('h7000, "R5");
        do_read('h77FF, "R5");
        do_read('h7800, "R5");
        do_read('h7FFF, "R5");
        do_read('h6FFF, "R5");
        do_write('h77FF, 'hFF, "R4");
        do_write('h7FFF, 'h00, "R4");
        do_read('h7123, "R5");
        do_read('h7ABC, "R5");
        do_read('h6100, "R4");
        // overlay off again
        do_write('h6FFF, 'h12, "R6");
        do_read('h7000, "R6");
        do_read('h7FFF, "R6");

        // mixed pseudo-random traffic
        begin
            int lcg;
            lcg = 32'h1234567;
            for (int i = 0; i < 600; i++) begin
                int kind, a, d;
                lcg = lcg * 1103515245 + 12345;
                kind = (lcg >>> 16) & 7;
                lcg = lcg * 1103515245 + 12345;
                d = (lcg >>> 16) & 'hFF;
                lcg = lcg * 1103515245 + 12345;
                a = (lcg >>> 8) & 'hFFFF;
                case (kind)
                    0: begin
                        int r;
                        r = d % 6;
                        a = (r == 0) ? 'h4FFF : (r == 1) ? 'h6FFF : (r == 2) ? 'h8FFF :
                            (r == 3) ? 'hAFFF : (r == 4) ? 'h77FF : 'h7FFF;
                        do_write(a, (d * 37) & 'hFF, "R2");
                    end
                    1: do_write(a % 'h4000, d, "R8");
                    2: do_read(a % 'h4000, "R7");
                    3: do_read('h7000 + (a % 'h1000), "R5");
                    4: do_read('h4000 + (a % 'h8000), "R3");
                    5: do_read('hC000 + (a % 'h4000), "R9");
                    6: do_write(a, d, "R4");
                    default: do_read(a, "R3");
                endcase
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule